// File: doc/BRIEF.md
# Host Write Port with Direct Transmit-FIFO Steering

This block is the receiving side of an asynchronous, SRAM-style host bus inside a synchronous chip. It watches the active-low chip-select and write-strobe pins, together with the address, a steering input and the data bus. It turns every completed host write into exactly one event in the system clock domain. Each write goes one of two ways. Either it becomes a one-clock pulse on a register-write interface, carrying the decoded word address, data and byte enables, or it becomes a 32-bit word pushed into a transmit data FIFO.

The steering input lets a host that insists on incrementing its address on every access stream data into the transmit FIFO. When the input is high, the upper address bits are not decoded and every write lands in the FIFO. The steering input is sampled with the same timing as the address lines.

The port works with a 32-bit data bus or with a 16-bit bus that uses only the lower data lines. In 16-bit mode, halfwords are combined into 32-bit FIFO words before they are pushed. A write that would complete a FIFO word while the FIFO reports full is dropped, and a sticky overrun flag is set.

Top module: `hostwr_port`

## Requirements
- R1: No event (neither `fifo_push` nor `reg_wr`) is produced unless `cs_n` and `wr_n` are both low at the same time. Pulsing only one of the two strobes has no effect.
- R2: Each write cycle produces exactly one event, after the cycle ends. A cycle ends when the first of `cs_n` and `wr_n` rises, and the two strobes may fall or rise in any order.
- R3: When `fifo_sel` is high during a write, the write targets the FIFO whatever the value of `addr` (A[7:1]). In 32-bit mode all address bits are ignored.
- R4: In 32-bit mode (`bus16`=0), a FIFO write pushes `fifo_data` equal to the full `data` value. `fifo_push` is high for exactly one clock and rises within four clocks after the strobes are released.
- R5: In 16-bit mode (`bus16`=1), a FIFO write with `addr[0]` (A1)=0 stores `data[15:0]` as the low halfword and pushes nothing. A FIFO write with A1=1 pushes the word {`data[15:0]`, stored low halfword}. `data[31:16]` is ignored.
- R6: When `fifo_sel` is low, the write produces a one-clock `reg_wr` pulse with `reg_addr` = `addr[6:1]` (A[7:2]) and no FIFO push.
- R7: Register writes carry byte enables. In 32-bit mode, `reg_be`=4'b1111 and `reg_data`=`data`. In 16-bit mode with A1=0, `reg_be`=4'b0011 and `reg_data`={16'h0, `data[15:0]`}. In 16-bit mode with A1=1, `reg_be`=4'b1100 and `reg_data`={`data[15:0]`, 16'h0}.
- R8: A write that would complete a FIFO word while `fifo_full` is high pushes nothing and sets `overrun`. `overrun` then stays high until reset, even after later successful pushes.
- R9: During and right after reset, `fifo_push`, `reg_wr` and `overrun` are low, and the stored low halfword is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| addr | input | ADDR_W | Host address A[7:1]; bit 0 is A1 |
| fifo_sel | input | 1 | High steers the write into the transmit FIFO |
| data | input | 32 | Host data bus |
| bus16 | input | 1 | 1 selects 16-bit bus mode (static) |
| fifo_full | input | 1 | Transmit FIFO full indication |
| fifo_push | output | 1 | One-clock push strobe |
| fifo_data | output | 32 | Word to push |
| reg_wr | output | 1 | One-clock register write strobe |
| reg_addr | output | ADDR_W-1 | Register word address A[7:2] |
| reg_data | output | 32 | Register write data, halfword positioned by A1 |
| reg_be | output | 4 | Register byte enables |
| overrun | output | 1 | Sticky FIFO overrun flag |

## Verification
The assertions assume that the host holds address, steering and data stable while both strobes are low. They also assume the strobes stay in each state for at least two system clocks, so the matched-delay samples line up with the strobe samples and successive cycle ends are separated. They further assume `bus16` does not change in the middle of a stream. The bench drives all inputs on falling clock edges, keeps the strobes low for three clocks and high for at least six, and changes `bus16` only between cycles. Within those limits it sweeps every address with the steering input in both states, and covers every release order, the halfword pairing, and the full FIFO.

// File: rtl/hostwr_pkg.sv
package hostwr_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int BE_W   = DATA_W / 8;
    localparam int HBE_W  = BE_W / 2;

    localparam logic [BE_W-1:0] BE_ALL  = {BE_W{1'b1}};
    localparam logic [BE_W-1:0] BE_LOW  = {{HBE_W{1'b0}}, {HBE_W{1'b1}}};
    localparam logic [BE_W-1:0] BE_HIGH = {{HBE_W{1'b1}}, {HBE_W{1'b0}}};

    function automatic logic [DATA_W-1:0] place_half(input logic [HALF_W-1:0] h,
                                                     input logic upper);
        return upper ? {h, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, h};
    endfunction
endpackage

// File: rtl/hostwr_sync.sv
module hostwr_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_q [STAGES];
    logic [W-1:0] st_d [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[g] <= RST_VAL;
            else        st_q[g] <= st_d[g];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/hostwr_cycle.sv
module hostwr_cycle #(
    parameter int ADDR_W = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s_cs_n,
    input  logic                          s_wr_n,
    input  logic                          s_sel,
    input  logic [ADDR_W-1:0]             s_addr,
    input  logic [hostwr_pkg::DATA_W-1:0] s_data,
    output logic                          end_evt,
    output logic                          cap_sel,
    output logic [ADDR_W-1:0]             cap_addr,
    output logic [hostwr_pkg::DATA_W-1:0] cap_data
);
    import hostwr_pkg::*;

    typedef struct packed {
        logic              act;
        logic              sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cyc_t;

    cyc_t st_d, st_q;
    logic act_now;

    assign act_now = ~s_cs_n & ~s_wr_n;

    always_comb begin
        st_d     = st_q;
        st_d.act = act_now;
        if (act_now) begin
            st_d.sel  = s_sel;
            st_d.addr = s_addr;
            st_d.data = s_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign end_evt  = st_q.act & ~act_now;
    assign cap_sel  = st_q.sel;
    assign cap_addr = st_q.addr;
    assign cap_data = st_q.data;

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> !end_evt); // R2
    AST_END_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |-> $past(!s_cs_n && !s_wr_n)); // R1
    AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !act_now |=> $stable(cap_data)); // R2
endmodule

// File: rtl/hostwr_pack.sv
module hostwr_pack #(
    parameter int ADDR_W = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          end_evt,
    input  logic                          cap_sel,
    input  logic [ADDR_W-1:0]             cap_addr,
    input  logic [hostwr_pkg::DATA_W-1:0] cap_data,
    input  logic                          bus16,
    input  logic                          fifo_full,
    output logic                          fifo_push,
    output logic [hostwr_pkg::DATA_W-1:0] fifo_data,
    output logic                          reg_wr,
    output logic [ADDR_W-2:0]             reg_addr,
    output logic [hostwr_pkg::DATA_W-1:0] reg_data,
    output logic [hostwr_pkg::BE_W-1:0]   reg_be,
    output logic                          overrun
);
    import hostwr_pkg::*;

    typedef struct packed {
        logic              push;
        logic [DATA_W-1:0] fdata;
        logic              regwr;
        logic [ADDR_W-2:0] raddr;
        logic [DATA_W-1:0] rdata;
        logic [BE_W-1:0]   rbe;
        logic [HALF_W-1:0] lo;
        logic              ovr;
    } pk_t;

    pk_t st_d, st_q;
    logic              a1;
    logic              low_only;
    logic [DATA_W-1:0] word;

    assign a1       = cap_addr[0];
    assign low_only = bus16 & ~a1;
    assign word     = bus16 ? {cap_data[HALF_W-1:0], st_q.lo} : cap_data;

    always_comb begin
        st_d       = st_q;
        st_d.push  = 1'b0;
        st_d.regwr = 1'b0;
        if (end_evt) begin
            if (cap_sel) begin
                if (low_only) begin
                    st_d.lo = cap_data[HALF_W-1:0];
                end else if (fifo_full) begin
                    st_d.ovr = 1'b1;
                end else begin
                    st_d.push  = 1'b1;
                    st_d.fdata = word;
                end
            end else begin
                st_d.regwr = 1'b1;
                st_d.raddr = cap_addr[ADDR_W-1:1];
                if (!bus16) begin
                    st_d.rdata = cap_data;
                    st_d.rbe   = BE_ALL;
                end else begin
                    st_d.rdata = place_half(cap_data[HALF_W-1:0], a1);
                    st_d.rbe   = a1 ? BE_HIGH : BE_LOW;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fifo_push = st_q.push;
    assign fifo_data = st_q.fdata;
    assign reg_wr    = st_q.regwr;
    assign reg_addr  = st_q.raddr;
    assign reg_data  = st_q.rdata;
    assign reg_be    = st_q.rbe;
    assign overrun   = st_q.ovr;

    AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !fifo_push); // R4
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && cap_sel && fifo_full) |=> !fifo_push); // R8
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8
    AST_PATH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && reg_wr)); // R6
    AST_LOW_HALF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && cap_sel && bus16 && !cap_addr[0]) |=> !fifo_push); // R5
    AST_REG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R6
endmodule

// File: rtl/hostwr_port.sv
module hostwr_port #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          wr_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          fifo_sel,
    input  logic [hostwr_pkg::DATA_W-1:0] data,
    input  logic                          bus16,
    input  logic                          fifo_full,
    output logic                          fifo_push,
    output logic [hostwr_pkg::DATA_W-1:0] fifo_data,
    output logic                          reg_wr,
    output logic [ADDR_W-2:0]             reg_addr,
    output logic [hostwr_pkg::DATA_W-1:0] reg_data,
    output logic [hostwr_pkg::BE_W-1:0]   reg_be,
    output logic                          overrun
);
    import hostwr_pkg::*;

    localparam int BUS_W = 3 + ADDR_W + DATA_W;
    localparam logic [BUS_W-1:0] BUS_IDLE = {2'b11, {(BUS_W-2){1'b0}}};

    logic [BUS_W-1:0]  raw_bus, sync_bus;
    logic              s_cs_n, s_wr_n, s_sel;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic              end_evt, cap_sel;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    assign raw_bus = {cs_n, wr_n, fifo_sel, addr, data};

    hostwr_sync #(
        .W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_bus), .dout(sync_bus)
    );

    assign {s_cs_n, s_wr_n, s_sel, s_addr, s_data} = sync_bus;

    hostwr_cycle #(.ADDR_W(ADDR_W)) u_cycle (
        .clk(clk), .rst_n(rst_n),
        .s_cs_n(s_cs_n), .s_wr_n(s_wr_n), .s_sel(s_sel),
        .s_addr(s_addr), .s_data(s_data),
        .end_evt(end_evt), .cap_sel(cap_sel),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    hostwr_pack #(.ADDR_W(ADDR_W)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .end_evt(end_evt), .cap_sel(cap_sel),
        .cap_addr(cap_addr), .cap_data(cap_data),
        .bus16(bus16), .fifo_full(fifo_full),
        .fifo_push(fifo_push), .fifo_data(fifo_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_data(reg_data), .reg_be(reg_be),
        .overrun(overrun)
    );
endmodule

// File: tb/tb_hostwr_port.sv
`timescale 1ns/1ps
module tb_hostwr_port;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, wr_n = 1'b1, fifo_sel = 1'b0, bus16 = 1'b0, fifo_full = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   data = '0;
    logic          fifo_push, reg_wr, overrun;
    logic [31:0]   fifo_data, reg_data;
    logic [AW-2:0] reg_addr;
    logic [3:0]    reg_be;

    int n_checks = 0, n_fail = 0;
    int push_cnt = 0, reg_cnt = 0, wide_cnt = 0;
    logic [31:0] last_fdata, last_rdata;
    logic [AW-2:0] last_raddr;
    logic [3:0] last_be;
    logic prev_push = 1'b0, prev_reg = 1'b0;

    always #2.5 clk = ~clk;

    hostwr_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .fifo_sel(fifo_sel), .data(data), .bus16(bus16), .fifo_full(fifo_full),
        .fifo_push(fifo_push), .fifo_data(fifo_data), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_data(reg_data), .reg_be(reg_be), .overrun(overrun)
    );

    always @(negedge clk) begin
        if (fifo_push) begin push_cnt++; last_fdata = fifo_data; end
        if (reg_wr) begin
            reg_cnt++; last_rdata = reg_data; last_raddr = reg_addr; last_be = reg_be;
        end
        if ((fifo_push && prev_push) || (reg_wr && prev_reg)) wide_cnt++;
        prev_push = fifo_push;
        prev_reg  = reg_wr;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // order: 0 both strobes together, 1 cs first (fall and rise), 2 wr first
    task automatic hwrite(input logic [AW-1:0] a, input logic s, input logic [31:0] d, input int order);
        @(negedge clk);
        addr = a; fifo_sel = s; data = d;
        if (order == 0) begin cs_n = 0; wr_n = 0; end
        else if (order == 1) begin cs_n = 0; @(negedge clk); wr_n = 0; end
        else begin wr_n = 0; @(negedge clk); cs_n = 0; end
        repeat (3) @(negedge clk);
        if (order == 0) begin cs_n = 1; wr_n = 1; end
        else if (order == 1) begin cs_n = 1; @(negedge clk); wr_n = 1; end
        else begin wr_n = 1; @(negedge clk); cs_n = 1; end
        addr = ~a; data = ~d; fifo_sel = ~s;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; cs_n = 1; wr_n = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int p0, r0;
        logic [31:0] d, lo;
        do_reset();
        // R9 reset state
        chk(!fifo_push && !reg_wr && !overrun, "R9 reset outputs", {29'd0, fifo_push, reg_wr, overrun}, 0);

        // R1 single strobes do nothing
        p0 = push_cnt; r0 = reg_cnt;
        @(negedge clk); fifo_sel = 1; cs_n = 0; repeat (5) @(negedge clk); cs_n = 1;
        repeat (2) @(negedge clk); wr_n = 0; repeat (5) @(negedge clk); wr_n = 1;
        fifo_sel = 0; repeat (2) @(negedge clk); wr_n = 0; repeat (5) @(negedge clk); wr_n = 1;
        repeat (6) @(negedge clk);
        chk(push_cnt == p0 && reg_cnt == r0, "R1 lone strobe", push_cnt + reg_cnt, p0 + r0);

        // R2 release orders
        for (int o = 0; o < 3; o++) begin
            p0 = push_cnt;
            d = 32'hA5A5_0000 + o;
            hwrite(7'h55, 1'b1, d, o);
            chk(push_cnt == p0 + 1, "R2 one event per cycle", push_cnt, p0 + 1);
            chk(last_fdata == d, "R2 data at end of cycle", last_fdata, d);
        end

        // R3 R4 R6 R7 32-bit sweep over all addresses and both steerings
        bus16 = 0;
        for (int a = 0; a < 128; a++) begin
            for (int s = 0; s < 2; s++) begin
                p0 = push_cnt; r0 = reg_cnt;
                d = (32'h9E37_79B9 * (a + 1)) ^ (s ? 32'h0F0F_F0F0 : 32'h1234_5678);
                hwrite(AW'(a), s[0], d, a % 3);
                if (s == 1) begin
                    chk(push_cnt == p0 + 1 && reg_cnt == r0, "R3 steered to fifo", push_cnt - p0, 1);
                    chk(last_fdata == d, "R4 fifo word", last_fdata, d);
                end else begin
                    chk(reg_cnt == r0 + 1 && push_cnt == p0, "R6 register path", reg_cnt - r0, 1);
                    chk(last_raddr == AW'(a) >> 1, "R6 word address", {26'd0, last_raddr}, a >> 1);
                    chk(last_rdata == d && last_be == 4'hF, "R7 32-bit reg data", last_rdata, d);
                end
            end
        end

        // R5 R7 16-bit mode
        bus16 = 1;
        for (int k = 0; k < 32; k++) begin
            p0 = push_cnt;
            lo = 32'hDEAD_0000 ^ (32'h0001_3579 * (k + 3));
            hwrite(AW'({k[5:0], 1'b0}), 1'b1, lo, 0);
            chk(push_cnt == p0, "R5 low half no push", push_cnt - p0, 0);
            d = 32'hBEEF_0000 ^ (32'h0002_468B * (k + 5));
            hwrite(AW'({~k[5:0], 1'b1}), 1'b1, d, k % 3);
            chk(push_cnt == p0 + 1, "R5 high half pushes", push_cnt - p0, 1);
            chk(last_fdata == {d[15:0], lo[15:0]}, "R5 packed word", last_fdata, {d[15:0], lo[15:0]});
        end
        for (int k = 0; k < 8; k++) begin
            d = 32'hC0DE_0000 + 32'(k * 977);
            hwrite(AW'(k * 9), 1'b0, d, 0);
            if (k[0] == 0 ? ((k * 9) % 2 == 0) : ((k * 9) % 2 == 0)) begin
                chk(last_be == 4'b0011 && last_rdata == {16'h0, d[15:0]}, "R7 16-bit low reg", last_rdata, {16'h0, d[15:0]});
            end else begin
                chk(last_be == 4'b1100 && last_rdata == {d[15:0], 16'h0}, "R7 16-bit high reg", last_rdata, {d[15:0], 16'h0});
            end
        end

        // R8 full FIFO
        bus16 = 0; fifo_full = 1;
        p0 = push_cnt;
        hwrite(7'h01, 1'b1, 32'h1111_2222, 0);
        chk(push_cnt == p0 && overrun, "R8 full drops and flags", {31'd0, overrun}, 1);
        fifo_full = 0;
        hwrite(7'h02, 1'b0, 32'h3333_4444, 0);
        hwrite(7'h03, 1'b1, 32'h5555_6666, 0);
        chk(push_cnt == p0 + 1 && overrun, "R8 overrun sticky", {31'd0, overrun}, 1);

        // R9 reset clears flag and stored half
        do_reset();
        chk(!overrun, "R9 overrun cleared", {31'd0, overrun}, 0);
        bus16 = 1;
        hwrite(7'h01, 1'b1, 32'hFFFF_ABCD, 0);
        chk(last_fdata == 32'hABCD_0000, "R9 low half cleared", last_fdata, 32'hABCD_0000);

        chk(wide_cnt == 0, "R4 strobes one clock wide", wide_cnt, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule